// File: doc/BRIEF.md
# Serial EEPROM Target Model

This block acts as the slave end of a four-wire SPI link and behaves like a small byte-wide serial EEPROM. It lets a controller design run in a closed loop against a synthesizable partner. The block oversamples the SPI pins with the system clock and decodes an opcode byte, a parameterised number of address bytes and a data phase. A status byte and a register-array memory stand behind the decoder.

Writes need a prior write-enable command. The bytes of a write are gathered in a one-page buffer, and the address wraps inside the current page. The buffer is copied into the array only when chip select rises on a byte boundary. A busy interval of a set number of cycles then starts, and during it the part answers only status reads. The link uses SPI mode 0: MOSI is sampled on the rising SCLK edge, and MISO changes on the falling edge, MSB first.

Top module: `spi_eeprom_target`

## Requirements
- R1: After reset the status byte reads 0x00 and spi_miso is 0.
- R2: Opcode 0x06 sets the write-enable latch (status bit 1) and opcode 0x04 clears it; both act when their opcode byte completes.
- R3: Opcode 0x05 returns the status byte on every following byte for as long as chip select stays low. The status byte is laid out as bit 7 protect-enable, bits 3:2 protect field, bit 1 write-enable latch, bit 0 busy, and all other bits 0.
- R4: With the write-enable latch set, opcode 0x01 followed by a data byte stores data bits 7, 3 and 2 into status bits 7, 3 and 2, and it clears the latch. With the latch clear the command has no effect.
- R5: Opcode 0x03 is followed by ADDR_BYTES address bytes, MSB first. It then streams the bytes at consecutive addresses on MISO while chip select is low, and it wraps from the last array address to address 0.
- R6: When OPC_ADDR_BIT is 1, opcodes 0x0B and 0x0A read and write with address bit 8*ADDR_BYTES set to 1. Bit 3 of the opcode supplies that address bit.
- R7: For opcode 0x02, data bytes go to consecutive offsets within the page of the start address and wrap to the page start. They are written into the array only if chip select rises on a byte boundary after at least one data byte.
- R8: A write or status-write received while the write-enable latch is clear is ignored. A write ended mid-byte is discarded, leaves the latch set and does not start busy.
- R9: A committed write sets busy for PROG_CYCLES cycles, and the write-enable latch clears when busy ends.
- R10: While busy, every command other than 0x05 is ignored and MISO returns 0x00 for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_csn | input | 1 | Active-low chip select |
| spi_miso | output | 1 | Serial data to the controller |

## Verification
Each MISO bit changes about four system clocks after a falling SCLK edge: two synchroniser stages, the edge detect and the output register. The bench holds each SCLK half-period for ten clocks and samples MISO just before raising SCLK. Busy shows within three clocks of chip select rising. The first status read after a write is therefore due well inside the busy window. The bench waits longer than PROG_CYCLES before it expects busy and the latch to be clear, so every expected status and data byte is compared in the byte slot where it must appear.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam logic [7:0] OP_WEN_SET = 8'h06;
  localparam logic [7:0] OP_WEN_CLR = 8'h04;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_STAT_WR = 8'h01;
  localparam logic [7:0] OP_MEM_RD  = 8'h03;
  localparam logic [7:0] OP_MEM_WR  = 8'h02;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_RDATA, PH_WDATA, PH_STAT, PH_WSTAT, PH_SKIP
  } phase_t;
endpackage

// File: rtl/spi_front.sv
module spi_front (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclk,
  input  logic       mosi,
  input  logic       csn,
  input  logic [7:0] tx_next,
  output logic       sel,
  output logic       sel_end,
  output logic       aligned,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       miso
);
  logic [2:0] sclk_p, csn_p;
  logic [1:0] mosi_p;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;
  logic       sclk_r, sclk_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= '0;
      csn_p  <= 3'b111;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      csn_p  <= {csn_p[1:0], csn};
      mosi_p <= {mosi_p[0], mosi};
    end
  end

  assign sclk_r  = sclk_p[1] & ~sclk_p[2];
  assign sclk_f  = ~sclk_p[1] & sclk_p[2];
  assign sel     = ~csn_p[1];
  assign sel_end = csn_p[1] & ~csn_p[2];
  assign aligned = (bit_cnt == 3'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      rx_sh     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
      tx_sh     <= '0;
      miso      <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!sel) begin
        bit_cnt <= '0;
        miso    <= 1'b0;
      end else begin
        if (sclk_r) begin
          rx_sh   <= {rx_sh[5:0], mosi_p[1]};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            rx_byte   <= {rx_sh, mosi_p[1]};
            byte_done <= 1'b1;
          end
        end
        if (sclk_f) begin
          if (bit_cnt == 3'd0) begin
            miso  <= tx_next[7];
            tx_sh <= {tx_next[6:0], 1'b0};
          end else begin
            miso  <= tx_sh[7];
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  AST_BYTE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    byte_done |-> aligned); // R5
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_eeprom_target.sv
module spi_eeprom_target
  import eeprom_pkg::*;
#(
  parameter int ADDR_BYTES   = 1,
  parameter int OPC_ADDR_BIT = 1,
  parameter int MEM_BYTES    = 512,
  parameter int PAGE_BYTES   = 16,
  parameter int PROG_CYCLES  = 4000
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_mosi,
  input  logic spi_csn,
  output logic spi_miso
);
  localparam int MW     = $clog2(MEM_BYTES);
  localparam int PW     = $clog2(PAGE_BYTES);
  localparam int A8     = ADDR_BYTES * 8;
  localparam int PROG_N = (PROG_CYCLES < PAGE_BYTES) ? PAGE_BYTES : PROG_CYCLES;
  localparam int CNTW   = $clog2(PROG_N + 1);

  logic          sel, fe_end, fe_aligned, fe_byte;
  logic [7:0]    rx, tx_next, mem_q, status;
  phase_t        ph;
  logic [7:0]    opc;
  logic [1:0]    acnt;
  logic [A8-1:0] a_sh, a_nx;
  logic [A8:0]   fa;
  logic [MW-1:0] ptr;
  logic [PW-1:0] woff, cidx;
  logic [MW-PW-1:0] cpage;
  logic [7:0]    pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pmask;
  logic          wgot, wel, wpen, cact, busy, mem_we;
  logic [1:0]    bp;
  logic [CNTW-1:0] bcnt;

  function automatic logic op_is(input logic [7:0] v, input logic [7:0] base);
    return (v == base) || ((OPC_ADDR_BIT != 0) && (v == (base | 8'h08)));
  endfunction

  spi_front u_front (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .mosi(spi_mosi), .csn(spi_csn),
    .tx_next(tx_next), .sel(sel), .sel_end(fe_end), .aligned(fe_aligned),
    .byte_done(fe_byte), .rx_byte(rx), .miso(spi_miso)
  );

  assign busy   = (bcnt != '0);
  assign status = {wpen, 3'b000, bp, wel, busy};
  assign a_nx   = (a_sh << 8) | A8'(rx);
  assign fa     = {((OPC_ADDR_BIT != 0) & opc[3]), a_nx};

  always_comb begin
    case (ph)
      PH_STAT:  tx_next = status;
      PH_RDATA: tx_next = mem_q;
      default:  tx_next = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_OPC;  opc <= '0;  acnt <= '0;  a_sh <= '0;  ptr <= '0;
      woff <= '0;  pmask <= '0;  wgot <= 1'b0;  wel <= 1'b0;  bp <= '0;
      wpen <= 1'b0;  bcnt <= '0;  cact <= 1'b0;  cidx <= '0;  cpage <= '0;
    end else begin
      if (busy) begin
        bcnt <= bcnt - CNTW'(1);
        if (bcnt == CNTW'(1)) wel <= 1'b0;
      end
      if (cact) begin
        cidx <= cidx + PW'(1);
        if (cidx == PW'(PAGE_BYTES - 1)) cact <= 1'b0;
      end
      if (fe_end) begin
        ph <= PH_OPC;
        if (ph == PH_WDATA && fe_aligned && wgot) begin
          bcnt  <= CNTW'(PROG_N);
          cact  <= 1'b1;
          cidx  <= '0;
          cpage <= ptr[MW-1:PW];
        end
      end else if (fe_byte) begin
        case (ph)
          PH_OPC: begin
            opc  <= rx;
            acnt <= 2'(ADDR_BYTES);
            a_sh <= '0;
            if (busy)                      ph <= (rx == OP_STAT_RD) ? PH_STAT : PH_SKIP;
            else if (rx == OP_WEN_SET) begin wel <= 1'b1; ph <= PH_SKIP; end
            else if (rx == OP_WEN_CLR) begin wel <= 1'b0; ph <= PH_SKIP; end
            else if (rx == OP_STAT_RD)     ph <= PH_STAT;
            else if (rx == OP_STAT_WR)     ph <= wel ? PH_WSTAT : PH_SKIP;
            else if (op_is(rx, OP_MEM_RD)) ph <= PH_ADDR;
            else if (op_is(rx, OP_MEM_WR)) ph <= wel ? PH_ADDR : PH_SKIP;
            else                           ph <= PH_SKIP;
          end
          PH_ADDR: begin
            a_sh <= a_nx;
            acnt <= acnt - 2'd1;
            if (acnt == 2'd1) begin
              ptr   <= fa[MW-1:0];
              woff  <= fa[PW-1:0];
              pmask <= '0;
              wgot  <= 1'b0;
              ph    <= op_is(opc, OP_MEM_RD) ? PH_RDATA : PH_WDATA;
            end
          end
          PH_RDATA: ptr <= ptr + MW'(1);
          PH_WDATA: begin
            pmask[woff] <= 1'b1;
            woff        <= woff + PW'(1);
            wgot        <= 1'b1;
          end
          PH_WSTAT: begin
            wpen <= rx[7];
            bp   <= rx[3:2];
            wel  <= 1'b0;
            ph   <= PH_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fe_byte && !fe_end && ph == PH_WDATA) pbuf[woff] <= rx;
  end

  assign mem_we = cact & pmask[cidx];

  eeprom_array #(.DEPTH(MEM_BYTES), .AW(MW)) u_array (
    .clk(clk), .we(mem_we), .waddr({cpage, cidx}), .wdata(pbuf[cidx]),
    .raddr(ptr), .rdata(mem_q)
  );

  AST_WEL_DROPS_WITH_BUSY: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel); // R9
  AST_COMMIT_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy); // R7
  AST_BUSY_STATUS_ONLY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(ph inside {PH_ADDR, PH_RDATA, PH_WDATA, PH_WSTAT})); // R10
  AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> wel); // R8
endmodule

// File: tb/tb_spi_eeprom_target.sv
module tb_spi_eeprom_target;
  localparam int HPC  = 10;
  localparam int WAIT = 4100;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, mosi = 1'b0, csn = 1'b1;
  logic miso;
  int n_tests = 0, n_fail = 0;
  logic [7:0] model [512];
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] act_q[$];
  bit         done = 1'b0;

  always #4 clk = ~clk;

  spi_eeprom_target dut (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_csn(csn), .spi_miso(miso)
  );

  task automatic half();
    repeat (HPC) @(negedge clk);
  endtask

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i]; half(); rx[i] = miso; sclk = 1'b1; half(); sclk = 1'b0;
    end
  endtask

  task automatic cs_lo(); csn = 1'b0; half(); endtask
  task automatic cs_hi(); half(); csn = 1'b1; repeat (3 * HPC) @(negedge clk); endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] r;
    bits(b, 8, r);
  endtask

  task automatic expect_byte(input logic [7:0] e, input string tag);
    logic [7:0] r;
    exp_q.push_back(e); tag_q.push_back(tag);
    bits(8'h00, 8, r);
    act_q.push_back(r);
  endtask

  task automatic cmd1(input logic [7:0] op);
    cs_lo(); send(op); cs_hi();
  endtask

  task automatic rdsr(input int n, input logic [7:0] e, input string tag);
    cs_lo(); send(8'h05);
    for (int i = 0; i < n; i++) expect_byte(e, tag);
    cs_hi();
  endtask

  task automatic wrsr(input logic [7:0] v);
    cs_lo(); send(8'h01); send(v); cs_hi();
  endtask

  task automatic wr(input logic [8:0] a, input int n, input logic [7:0] d0,
                    input bit commit);
    cs_lo(); send(8'h02 | {4'h0, a[8], 3'b000}); send(a[7:0]);
    for (int i = 0; i < n; i++) begin
      send(d0 + 8'(i));
      if (commit) model[{a[8:4], 4'(a[3:0] + 4'(i))}] = d0 + 8'(i);
    end
    cs_hi();
  endtask

  task automatic rd(input logic [8:0] a, input int n, input bit zero, input string tag);
    cs_lo(); send(8'h03 | {4'h0, a[8], 3'b000}); send(a[7:0]);
    for (int i = 0; i < n; i++) expect_byte(zero ? 8'h00 : model[9'(a + 9'(i))], tag);
    cs_hi();
  endtask

  task automatic settle(); repeat (WAIT) @(negedge clk); endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // monitor: pops captured bytes and compares them with the queued expectations
  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0) begin
      logic [7:0] a, e;
      string t;
      a = act_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      n_tests++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: got %02h expected %02h", t, a, e);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    n_tests++;
    if (miso !== 1'b0) begin
      n_fail++; $display("FAIL R1 miso after reset: got %b expected 0", miso);
    end
    rdsr(1, 8'h00, "R1 reset status");

    cmd1(8'h06); rdsr(3, 8'h02, "R2/R3 latch set, repeated status");
    cmd1(8'h04); rdsr(1, 8'h00, "R2 latch cleared");

    wr(9'h040, 1, 8'hA1, 1'b0);
    rdsr(1, 8'h00, "R8 write without latch starts no busy");

    cmd1(8'h06); wr(9'h040, 4, 8'h10, 1'b1);
    rdsr(1, 8'h03, "R9 busy right after commit");
    settle();
    rdsr(1, 8'h00, "R9 busy ended, latch cleared");
    rd(9'h040, 4, 1'b0, "R5/R7 read back page data");

    wr(9'h041, 1, 8'hFF, 1'b0); settle();
    rd(9'h041, 1, 1'b0, "R8 unlatched write left data");

    cmd1(8'h06); wr(9'h04E, 4, 8'h20, 1'b1); settle();
    rd(9'h04E, 2, 1'b0, "R7 page end bytes");
    rd(9'h040, 4, 1'b0, "R7 wrapped to page start");

    cmd1(8'h06); wr(9'h060, 1, 8'h55, 1'b1);
    cmd1(8'h04);
    rdsr(1, 8'h03, "R10 clear-latch ignored while busy");
    wr(9'h060, 1, 8'h66, 1'b0);
    wrsr(8'h8C);
    rd(9'h060, 1, 1'b1, "R10 read ignored while busy");
    settle();
    rdsr(1, 8'h00, "R10 status write ignored while busy");
    rd(9'h060, 1, 1'b0, "R10 write ignored while busy");

    cmd1(8'h06);
    cs_lo(); send(8'h02); send(8'h60); send(8'h77); bits(8'hF0, 4, r); cs_hi();
    rdsr(1, 8'h02, "R8 mid-byte end keeps latch, no busy");
    rd(9'h060, 1, 1'b0, "R7 mid-byte write discarded");
    cmd1(8'h04);

    cmd1(8'h06); wr(9'h140, 1, 8'h99, 1'b1); settle();
    rd(9'h140, 1, 1'b0, "R6 upper region via opcode bit 3");
    rd(9'h040, 1, 1'b0, "R6 lower region untouched");

    cmd1(8'h06); wr(9'h1FF, 1, 8'h5A, 1'b1); settle();
    cmd1(8'h06); wr(9'h000, 1, 8'hA5, 1'b1); settle();
    rd(9'h1FF, 2, 1'b0, "R5 read wraps last address to 0");

    cmd1(8'h06); wrsr(8'h8C);
    rdsr(1, 8'h8C, "R4 status bits stored, latch cleared");
    wrsr(8'h00);
    rdsr(1, 8'h8C, "R4 status write ignored without latch");
    cmd1(8'h06); wrsr(8'hF3);
    rdsr(2, 8'h80, "R4 only bits 7,3,2 stored");

    repeat (20) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule